// File: doc/BRIEF.md
# Variable-Length Serial Codec Port

This block is a synchronous serial port for compressed voice samples. It has a receive half and a transmit half. Each half has its own bit clock and its own frame-sync input. Both halves are oversampled by one system clock `clk`, and every edge of a bit clock or frame sync is detected against that clock.

On receive, the port counts the falling bit-clock edges that occur while the frame sync is high. Data is sampled on those same edges, most significant bit first. When the frame sync drops, the count picks the word length and the coding rate for that frame:

| Count | Word length | Rate code | Rate |
|-------|-------------|-----------|------|
| 2 | 2 bits | 0 | 16 kbps |
| 3 | 3 bits | 1 | 24 kbps |
| 4 | 4 bits | 2 | 32 kbps |
| 8 | 8 bits | 3 | 64 kbps PCM |

The port then raises a one-cycle word-ready interrupt and presents the word and its rate code. Because the length is measured on every frame, the format can change from one frame to the next.

On transmit, a rising frame sync loads a parallel word and its rate code. The port drives the word out MSB first, one bit per rising bit-clock edge. It asserts an output enable only while the word is on the line; that enable stands in for the tri-state control of the data pin.

Top module: `vlsp_top`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a `clk` edge), `rx_irq`, `rx_word`, `rx_rate`, `tx_dout` and `tx_oe` are all 0.
- R2: A receive frame with exactly 2, 3, 4 or 8 counted falling `rx_bclk` edges reports `rx_rate` 0, 1, 2 or 3 respectively.
- R3: Receive bits are sampled on falling `rx_bclk` edges while `rx_fs` is high, first bit most significant. `rx_word` holds the word right-aligned in bits [L-1:0], and all bits above L-1 are 0.
- R4: `rx_irq` is high for exactly one `clk` cycle. It appears at the first `clk` edge that sees `rx_fs` low after being high, and `rx_word`/`rx_rate` are valid in that cycle.
- R5: A count of 0 or 1 is treated as length 2, and a count of 5, 6 or 7 as length 8. A count above 8 is treated as length 8, and the word is the last 8 bits sampled. When fewer bits are sampled than the length, the missing leading bits read as 0.
- R6: Consecutive receive frames may each use a different length, and each frame is decoded on its own count.
- R7: `tx_oe` rises at the `clk` edge that first sees `tx_fs` high. `tx_dout` then carries bit L-1 of `tx_word`, and it moves to the next lower bit at each later rising `tx_bclk` edge.
- R8: With `tx_cut` = 0, `tx_oe` stays high until the L-th falling `tx_bclk` edge of the frame, even if `tx_fs` drops earlier. It falls at the `clk` edge that sees that falling edge.
- R9: With `tx_cut` = 1, `tx_oe` also falls at the first `clk` edge that sees `tx_fs` low, if that comes before the L-th falling edge.
- R10: The transmit length L is taken from `tx_rate` (0 gives 2 bits, 1 gives 3, 2 gives 4, 3 gives 8), and only the low L bits of `tx_word` are sent. Whenever `tx_oe` is low, `tx_dout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples all serial inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fs | input | 1 | Receive frame sync; its high time sets the word length |
| rx_din | input | 1 | Receive serial data |
| rx_irq | output | 1 | One-cycle word-ready pulse |
| rx_word | output | 8 | Received word, right-aligned |
| rx_rate | output | 2 | Rate code of the received word |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fs | input | 1 | Transmit frame sync; its rising edge starts a word |
| tx_cut | input | 1 | 1: output enable also ends when `tx_fs` falls |
| tx_word | input | 8 | Word to send, right-aligned |
| tx_rate | input | 2 | Rate code selecting the transmit length |
| tx_dout | output | 1 | Transmit serial data |
| tx_oe | output | 1 | High while `tx_dout` drives the line |

## Verification
The word-ready pulse is due exactly one `clk` edge after the frame sync is driven low. The scoreboard entry pushed by the driver records that clock index, and the monitor checks the index of the pulse against it, along with the word and the rate code.

On transmit, every output change follows exactly one `clk` edge after the bit-clock or frame-sync change that causes it. The bench holds each bit-clock phase for four clocks and samples `tx_dout` and `tx_oe` two clocks into each phase, so it always reads settled values. The expected enable is computed from the bit index, the frame-sync length and the cut mode.

// File: rtl/vlsp_pkg.sv
// Package: shared widths, rate type and the length/rate decode rules of the
// variable-length serial codec port.
package vlsp_pkg;

    localparam int WORD_W = 8;   // longest word (64 kbps PCM)
    localparam int CNT_W  = 4;   // saturating frame-length counter width
    localparam int LEN_W  = 4;   // holds a length up to WORD_W

    typedef logic [1:0] rate_t;

    // Map a counted frame-sync length to a rate code, rounding up.
    function automatic rate_t rate_of_count(input logic [CNT_W-1:0] n);
        if (n <= CNT_W'(2))      return 2'd0;
        else if (n == CNT_W'(3)) return 2'd1;
        else if (n == CNT_W'(4)) return 2'd2;
        else                     return 2'd3;
    endfunction

    // Word length in bits for a rate code.
    function automatic logic [LEN_W-1:0] len_of_rate(input rate_t r);
        case (r)
            2'd0:    return LEN_W'(2);
            2'd1:    return LEN_W'(3);
            2'd2:    return LEN_W'(4);
            default: return LEN_W'(WORD_W);
        endcase
    endfunction

    // Mask with the low len bits set.
    function automatic logic [WORD_W-1:0] low_mask(input logic [LEN_W-1:0] len);
        logic [WORD_W-1:0] one;
        one = WORD_W'(1);
        return (one << len) - one;
    endfunction

endpackage

// File: rtl/vlsp_edge.sv
// Module: vlsp_edge
// Detects rising and falling transitions of one slow serial signal against
// the system clock.
// Assumes: the input is already synchronous to clk and changes at most once
// per clk cycle.
module vlsp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);

    logic prev;

    // Keep last cycle's value of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= sig;
    end

    assign rise = sig & ~prev;
    assign fall = ~sig & prev;

endmodule

// File: rtl/vlsp_rx.sv
// Module: vlsp_rx
// Receive half: counts falling bit-clock edges during the frame sync,
// shifts data in MSB first, and decodes length and rate when the sync drops.
// Assumes: rx inputs are synchronous to clk, and a bit-clock edge never
// coincides with a frame-sync edge.
module vlsp_rx
    import vlsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk,
    input  logic              fs,
    input  logic              din,
    output logic              irq,
    output logic [WORD_W-1:0] word,
    output rate_t             rate
);

    logic             bclk_rise_unused;
    logic             bclk_fall;
    logic             fs_rise;
    logic             fs_fall;
    logic [CNT_W-1:0] cnt;
    logic [WORD_W-1:0] sh;

    vlsp_edge u_bclk_edge (
        .clk(clk), .rst_n(rst_n), .sig(bclk),
        .rise(bclk_rise_unused), .fall(bclk_fall)
    );

    vlsp_edge u_fs_edge (
        .clk(clk), .rst_n(rst_n), .sig(fs),
        .rise(fs_rise), .fall(fs_fall)
    );

    // Count and capture bits during the frame; publish the word when the frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            sh   <= '0;
            irq  <= 1'b0;
            word <= '0;
            rate <= 2'd0;
        end else begin
            irq <= 1'b0;
            if (fs_rise) begin
                cnt <= '0;
                sh  <= '0;
            end else if (fs && bclk_fall) begin
                if (cnt != '1) cnt <= cnt + 1'b1;
                sh <= {sh[WORD_W-2:0], din};
            end
            if (fs_fall) begin
                irq  <= 1'b1;
                rate <= rate_of_count(cnt);
                word <= sh & low_mask(len_of_rate(rate_of_count(cnt)));
            end
        end
    end

    // R4: the ready pulse lasts one cycle.
    a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R4: a ready pulse only follows an observed frame-sync fall.
    a_r4_irq_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(fs_fall));

    // R3: the published word never has bits above its length.
    a_r3_word_fits: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((word & ~low_mask(len_of_rate(rate))) == '0));

endmodule

// File: rtl/vlsp_tx.sv
// Module: vlsp_tx
// Transmit half: loads a word on frame-sync rise, shifts it out MSB first on
// rising bit-clock edges, and holds the enable for L falling edges (or until
// the sync falls in cut mode).
// Assumes: the frame sync rises together with, or before, the first rising
// bit-clock edge of the word.
module vlsp_tx
    import vlsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk,
    input  logic              fs,
    input  logic              cut,
    input  logic [WORD_W-1:0] word_in,
    input  rate_t             rate_in,
    output logic              dout,
    output logic              oe
);

    logic              bclk_rise;
    logic              bclk_fall;
    logic              fs_rise;
    logic              fs_fall;
    logic              active;
    logic [WORD_W-1:0] sh;
    logic [LEN_W-1:0]  rem;
    logic [LEN_W-1:0]  len_now;

    vlsp_edge u_bclk_edge (
        .clk(clk), .rst_n(rst_n), .sig(bclk),
        .rise(bclk_rise), .fall(bclk_fall)
    );

    vlsp_edge u_fs_edge (
        .clk(clk), .rst_n(rst_n), .sig(fs),
        .rise(fs_rise), .fall(fs_fall)
    );

    assign len_now = len_of_rate(rate_in);

    // Load, shift and time the output enable of one transmit word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            sh     <= '0;
            rem    <= '0;
        end else if (fs_rise) begin
            active <= 1'b1;
            sh     <= word_in << (LEN_W'(WORD_W) - len_now);
            rem    <= len_now;
        end else if (active) begin
            if (cut && fs_fall) begin
                active <= 1'b0;
            end else if (bclk_fall) begin
                rem <= rem - 1'b1;
                if (rem == LEN_W'(1)) active <= 1'b0;
            end
            if (bclk_rise) sh <= sh << 1;
        end
    end

    assign dout = active & sh[WORD_W-1];
    assign oe   = active;

    // R7: the enable only starts on a frame-sync rise.
    a_r7_oe_starts_on_fs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(fs_rise));

    // R8: without cut mode the enable only ends on a falling bit-clock edge.
    a_r8_oe_ends_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(oe) && !$past(cut)) |-> $past(bclk_fall));

    // R7: data holds steady within a word except after a rising bit-clock edge.
    a_r7_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && $past(oe) && !$past(bclk_rise)) |-> (dout == $past(dout)));

endmodule

// File: rtl/vlsp_top.sv
// Module: vlsp_top
// Variable-length serial codec port: independent receive and transmit halves
// sharing one oversampling system clock.
// Assumes: all serial inputs are synchronous to clk.
module vlsp_top
    import vlsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bclk,
    input  logic              rx_fs,
    input  logic              rx_din,
    output logic              rx_irq,
    output logic [WORD_W-1:0] rx_word,
    output logic [1:0]        rx_rate,
    input  logic              tx_bclk,
    input  logic              tx_fs,
    input  logic              tx_cut,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [1:0]        tx_rate,
    output logic              tx_dout,
    output logic              tx_oe
);

    vlsp_rx u_rx (
        .clk(clk), .rst_n(rst_n), .bclk(rx_bclk), .fs(rx_fs), .din(rx_din),
        .irq(rx_irq), .word(rx_word), .rate(rx_rate)
    );

    vlsp_tx u_tx (
        .clk(clk), .rst_n(rst_n), .bclk(tx_bclk), .fs(tx_fs), .cut(tx_cut),
        .word_in(tx_word), .rate_in(tx_rate), .dout(tx_dout), .oe(tx_oe)
    );

    // R10: the line is quiet whenever the enable is low.
    a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> !tx_dout);

endmodule

// File: tb/vlsp_top_tb.sv
module vlsp_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bclk = 1'b0, rx_fs = 1'b0, rx_din = 1'b0;
    logic       rx_irq;
    logic [7:0] rx_word;
    logic [1:0] rx_rate;
    logic       tx_bclk = 1'b0, tx_fs = 1'b0, tx_cut = 1'b0;
    logic [7:0] tx_word = 8'h00;
    logic [1:0] tx_rate = 2'd0;
    logic       tx_dout, tx_oe;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    typedef struct {
        logic [7:0] w;
        logic [1:0] r;
        int         at;
        int         req;
    } exp_t;
    exp_t q[$];

    vlsp_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .rx_bclk(rx_bclk), .rx_fs(rx_fs), .rx_din(rx_din),
        .rx_irq(rx_irq), .rx_word(rx_word), .rx_rate(rx_rate),
        .tx_bclk(tx_bclk), .tx_fs(tx_fs), .tx_cut(tx_cut),
        .tx_word(tx_word), .tx_rate(tx_rate),
        .tx_dout(tx_dout), .tx_oe(tx_oe)
    );

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int len_of(input int rate);
        case (rate)
            0: return 2;
            1: return 3;
            2: return 4;
            default: return 8;
        endcase
    endfunction

    function automatic int rate_for(input int n);
        if (n <= 2) return 0;
        if (n == 3) return 1;
        if (n == 4) return 2;
        return 3;
    endfunction

    // Monitor: pop the scoreboard on each ready pulse and compare.
    always @(negedge clk) begin
        if (rst_n && rx_irq) begin
            if (q.size() == 0) begin
                chk(1'b0, "R4", "unexpected ready pulse", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(rx_word == e.w, $sformatf("R%0d", e.req), "rx word", rx_word, e.w);
                chk(rx_rate == e.r, $sformatf("R%0d", e.req), "rx rate", rx_rate, e.r);
                chk(cyc == e.at, "R4", "ready pulse cycle", cyc, e.at);
            end
        end
    end

    // Driver: send one receive frame of n counted bit clocks and queue the expectation.
    task automatic rx_frame(input int n, input logic [15:0] bits, input int req);
        logic [7:0] acc;
        exp_t e;
        int len;
        acc = 8'h00;
        @(negedge clk); rx_fs = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            rx_bclk = 1'b1;
            rx_din  = bits[i];
            acc     = {acc[6:0], bits[i]};
            repeat (4) @(negedge clk);
            rx_bclk = 1'b0;
            repeat (4) @(negedge clk);
        end
        len   = len_of(rate_for(n));
        e.r   = 2'(rate_for(n));
        e.w   = acc & 8'((1 << len) - 1);
        e.at  = cyc + 1;
        e.req = req;
        q.push_back(e);
        rx_fs = 1'b0;
        // Trailing bit clock with the sync low must not count.
        rx_bclk = 1'b1; rx_din = 1'b1;
        repeat (4) @(negedge clk);
        rx_bclk = 1'b0; rx_din = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Send one transmit word and check enable and data mid-phase.
    task automatic tx_frame(input logic [7:0] w, input int rate, input int fs_cyc,
                            input bit cut, input string req);
        int  len;
        bit  exp_oe;
        bit  exp_d;
        len     = len_of(rate);
        tx_word = w;
        tx_rate = 2'(rate);
        tx_cut  = cut;
        for (int j = 0; j <= len; j++) begin
            @(negedge clk);
            tx_bclk = 1'b1;
            tx_fs   = (j < fs_cyc);
            repeat (2) @(negedge clk);
            exp_oe = (j < len) && (!cut || j < fs_cyc);
            exp_d  = exp_oe && w[len-1-(j < len ? j : 0)];
            chk(tx_oe == exp_oe, req, $sformatf("oe high phase bit %0d", j), tx_oe, exp_oe);
            chk(tx_dout == exp_d, req, $sformatf("dout high phase bit %0d", j), tx_dout, exp_d);
            @(negedge clk);
            @(negedge clk);
            tx_bclk = 1'b0;
            repeat (2) @(negedge clk);
            exp_oe = (j + 1 < len) && (!cut || j < fs_cyc);
            exp_d  = exp_oe && w[len-1-(j < len ? j : 0)];
            chk(tx_oe == exp_oe, req, $sformatf("oe low phase bit %0d", j), tx_oe, exp_oe);
            chk(tx_dout == exp_d, req, $sformatf("dout low phase bit %0d", j), tx_dout, exp_d);
            @(negedge clk);
        end
        tx_fs = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(rx_irq == 1'b0, "R1", "rx_irq", rx_irq, 0);
        chk(rx_word == 8'h00, "R1", "rx_word", rx_word, 0);
        chk(rx_rate == 2'd0, "R1", "rx_rate", rx_rate, 0);
        chk(tx_oe == 1'b0, "R1", "tx_oe", tx_oe, 0);
        chk(tx_dout == 1'b0, "R1", "tx_dout", tx_dout, 0);

        // R2 / R3: legal lengths with distinct patterns
        rx_frame(2, 16'b10, 2);
        rx_frame(3, 16'b101, 2);
        rx_frame(4, 16'b1001, 3);
        rx_frame(8, 16'b1011_0010, 3);
        // R5: rounding and saturation
        rx_frame(0, 16'h0000, 5);
        rx_frame(1, 16'h0001, 5);
        rx_frame(5, 16'b10111, 5);
        rx_frame(7, 16'b1101101, 5);
        rx_frame(11, 16'b101_1100_1011, 5);
        // R6: format changes frame by frame
        rx_frame(4, 16'b0110, 6);
        rx_frame(2, 16'b11, 6);
        rx_frame(8, 16'b0101_1110, 6);
        rx_frame(3, 16'b011, 6);
        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R4", "pending ready pulses", q.size(), 0);

        // R7 / R10: each rate, sync covering the word
        tx_frame(8'hB5, 3, 8, 1'b0, "R7");
        tx_frame(8'hFE, 0, 2, 1'b0, "R10");
        tx_frame(8'h0D, 1, 3, 1'b0, "R10");
        tx_frame(8'h3A, 2, 4, 1'b0, "R7");
        // R8: short sync, counted enable
        tx_frame(8'h96, 3, 1, 1'b0, "R8");
        tx_frame(8'h05, 2, 2, 1'b0, "R8");
        // R9: short sync, cut enable
        tx_frame(8'hC3, 3, 3, 1'b1, "R9");
        tx_frame(8'h0B, 2, 1, 1'b1, "R9");
        tx_frame(8'h06, 1, 3, 1'b1, "R9");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule